// File: doc/BRIEF.md
# Saturating Clip Unit with Sticky Status

This block narrows a 32-bit register value to the range of a signed or unsigned byte or halfword. If the value lies outside the chosen range, the block replaces it with the nearest limit. Otherwise the value passes through unchanged. The result is registered, so it appears one clock after the operation strobe.

The block also keeps a sticky status bit that records whether any operation ever had to clamp. Only an explicit clear input resets this bit. An operation that leaves its value unchanged does not touch it.

A small decoder sits next to the datapath. It recognises the four 16-bit clip instruction words and reports the register field and the two mode selects that drive the unit.

Top module: `sat_clip_unit`

## Requirements
- R1: After reset, `result` is 0x00000000 and `clip_flag` is 0.
- R2: Signed byte mode (`op_signed`=1, `op_word`=0) compares the operand as a signed value. It gives 0x0000007F for operands above +127 and 0xFFFFFF80 for operands below -128.
- R3: Signed halfword mode (`op_signed`=1, `op_word`=1) gives 0x00007FFF for operands above +32767 and 0xFFFF8000 for operands below -32768.
- R4: The unsigned modes (`op_signed`=0) compare the operand as an unsigned 32-bit value. Byte mode gives 0x000000FF for operands above 255. Halfword mode gives 0x0000FFFF for operands above 65535. Neither unsigned mode has a lower limit.
- R5: An operand within the selected range, including one equal to a limit, appears on `result` unchanged and does not set `clip_flag`.
- R6: The result of an operation strobed with `op_valid` appears on `result` after the next rising clock edge. While `op_valid` is low, `result` holds its value.
- R7: `clip_flag` becomes 1 after any operation that clamps. An operation that does not clamp never clears it.
- R8: `flag_clear` high at a clock edge clears `clip_flag`. If a clamping operation happens at the same edge, the flag ends at 1.
- R9: The decoder flags a hit only for instruction words of the form 0100_rrrr_100s_0w01. Bit 4 (s) selects signed, bit 2 (w) selects halfword, and bits 11:8 (rrrr) give the register index. Every other word is a miss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Performs a clip operation this cycle |
| op_signed | input | 1 | 1 selects a signed range, 0 an unsigned range |
| op_word | input | 1 | 1 selects halfword, 0 byte |
| operand | input | 32 | Value to be clipped |
| flag_clear | input | 1 | Clears the sticky status bit |
| result | output | 32 | Registered clipped value |
| clip_flag | output | 1 | Sticky clamp status |

## Verification
The bench applies operands that sit exactly on each limit and one step past it, in every mode. A design that compared with >= instead of > would clamp the limit values and raise the flag for them. The bench also uses operands with the top bit set in the unsigned modes. A design that compared them as signed would pass them through instead of clamping them to the upper limit. Finally, the bench follows a clamping operation with non-clamping ones, and it asserts the clear in the same cycle as a clamp. A flag that merely reflected the last operation, or that let the clear take priority, would read 0 at those points.

// File: rtl/sat_clip_pkg.sv
package sat_clip_pkg;
    localparam int DATA_W = 32;
    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;
    localparam int NUM_LANES = 2;

    typedef struct packed {
        logic [DATA_W-1:0] result;
        logic              flag;
    } clip_state_t;
endpackage

// File: rtl/clip_insn_decode.sv
module clip_insn_decode (
    input  logic [15:0] insn,
    output logic        hit,
    output logic        is_signed,
    output logic        is_word,
    output logic [3:0]  reg_idx
);
    always_comb begin
        hit       = (insn[15:12] == 4'b0100) && insn[7] && (insn[6:5] == 2'b00)
                    && !insn[3] && (insn[1:0] == 2'b01);
        is_signed = insn[4];
        is_word   = insn[2];
        reg_idx   = insn[11:8];
    end
endmodule

// File: rtl/clip_lane.sv
module clip_lane #(
    parameter int DATA_W   = 32,
    parameter int NARROW_W = 8
) (
    input  logic [DATA_W-1:0] din,
    input  logic              is_signed,
    output logic [DATA_W-1:0] dout,
    output logic              clipped
);
    localparam logic [DATA_W-1:0] SMAX = {{(DATA_W-NARROW_W+1){1'b0}}, {(NARROW_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] SMIN = ~SMAX;
    localparam logic [DATA_W-1:0] UMAX = {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    logic hi_s, lo_s, hi_u;

    always_comb begin
        hi_s = $signed(din) > $signed(SMAX);
        lo_s = $signed(din) < $signed(SMIN);
        hi_u = din > UMAX;
        dout    = din;
        clipped = 1'b0;
        if (is_signed) begin
            if (hi_s) begin
                dout    = SMAX;
                clipped = 1'b1;
            end else if (lo_s) begin
                dout    = SMIN;
                clipped = 1'b1;
            end
        end else if (hi_u) begin
            dout    = UMAX;
            clipped = 1'b1;
        end
    end
endmodule

// File: rtl/sat_clip_unit.sv
module sat_clip_unit
    import sat_clip_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic              op_signed,
    input  logic              op_word,
    input  logic [DATA_W-1:0] operand,
    input  logic              flag_clear,
    output logic [DATA_W-1:0] result,
    output logic              clip_flag
);
    logic [DATA_W-1:0] lane_out  [NUM_LANES];
    logic              lane_clip [NUM_LANES];

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        clip_lane #(
            .DATA_W  (DATA_W),
            .NARROW_W((g == 0) ? BYTE_W : HALF_W)
        ) u_lane (
            .din      (operand),
            .is_signed(op_signed),
            .dout     (lane_out[g]),
            .clipped  (lane_clip[g])
        );
    end

    logic [DATA_W-1:0] sel_out;
    logic              sel_clip;
    clip_state_t       st_d, st_q;

    always_comb begin
        sel_out  = op_word ? lane_out[1]  : lane_out[0];
        sel_clip = op_word ? lane_clip[1] : lane_clip[0];
        st_d = st_q;
        if (flag_clear)
            st_d.flag = 1'b0;
        if (op_valid) begin
            st_d.result = sel_out;
            if (sel_clip)
                st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign result    = st_q.result;
    assign clip_flag = st_q.flag;

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(result));

    // R5
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !sel_clip) |=> (result == $past(operand)));

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clip_flag && !flag_clear) |=> clip_flag);

    // R8
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clear && !(op_valid && sel_clip)) |=> !clip_flag);

    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && sel_clip) |=> clip_flag);
endmodule

// File: tb/sat_clip_unit_test.sv
module sat_clip_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_signed = 1'b0;
    logic        op_word = 1'b0;
    logic [31:0] operand = '0;
    logic        flag_clear = 1'b0;
    logic [31:0] result;
    logic        clip_flag;

    logic [15:0] insn = '0;
    logic        d_hit, d_sgn, d_wrd;
    logic [3:0]  d_reg;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    sat_clip_unit uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_signed(op_signed),
        .op_word(op_word), .operand(operand), .flag_clear(flag_clear),
        .result(result), .clip_flag(clip_flag)
    );

    clip_insn_decode dec (
        .insn(insn), .hit(d_hit), .is_signed(d_sgn), .is_word(d_wrd), .reg_idx(d_reg)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clip(bit sgn, bit wrd, logic [31:0] val, bit clr,
                        logic [31:0] exp_res, bit exp_flag, string tag);
        @(negedge clk);
        op_valid = 1'b1; op_signed = sgn; op_word = wrd; operand = val; flag_clear = clr;
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0; flag_clear = 1'b0;
        check({tag, " result"}, result, exp_res);
        check({tag, " flag"}, {31'b0, clip_flag}, {31'b0, exp_flag});
    endtask

    task automatic clear_flag();
        @(negedge clk);
        flag_clear = 1'b1;
        @(posedge clk);
        @(negedge clk);
        flag_clear = 1'b0;
        check("R8 clear", {31'b0, clip_flag}, 32'd0);
    endtask

    task automatic t_reset();
        check("R1 result", result, 32'h0);
        check("R1 flag", {31'b0, clip_flag}, 32'd0);
    endtask

    task automatic t_bounds();
        clip(1, 0, 32'h0000007F, 0, 32'h0000007F, 0, "R5 sb max");
        clip(1, 0, 32'hFFFFFF80, 0, 32'hFFFFFF80, 0, "R5 sb min");
        clip(1, 1, 32'h00007FFF, 0, 32'h00007FFF, 0, "R5 sw max");
        clip(1, 1, 32'hFFFF8000, 0, 32'hFFFF8000, 0, "R5 sw min");
        clip(0, 0, 32'h000000FF, 0, 32'h000000FF, 0, "R5 ub max");
        clip(0, 1, 32'h0000FFFF, 0, 32'h0000FFFF, 0, "R5 uw max");
        clip(0, 0, 32'h00000000, 0, 32'h00000000, 0, "R5 ub zero");
    endtask

    task automatic t_signed();
        clip(1, 0, 32'h00000080, 0, 32'h0000007F, 1, "R2 sb over");
        clear_flag();
        clip(1, 0, 32'hFFFFFF7F, 0, 32'hFFFFFF80, 1, "R2 sb under");
        clip(1, 0, 32'h80000000, 0, 32'hFFFFFF80, 1, "R2 sb most negative");
        clear_flag();
        clip(1, 1, 32'h12345678, 0, 32'h00007FFF, 1, "R3 sw over");
        clear_flag();
        clip(1, 1, 32'hFFFF7FFF, 0, 32'hFFFF8000, 1, "R3 sw under");
        clear_flag();
        clip(1, 1, 32'h00008000, 0, 32'h00007FFF, 1, "R3 sw one past");
        clear_flag();
    endtask

    task automatic t_unsigned();
        clip(0, 0, 32'hFFFFFFFF, 0, 32'h000000FF, 1, "R4 ub top bit set");
        clear_flag();
        clip(0, 0, 32'h00000100, 0, 32'h000000FF, 1, "R4 ub one past");
        clear_flag();
        clip(0, 1, 32'h80000000, 0, 32'h0000FFFF, 1, "R4 uw top bit set");
        clear_flag();
        clip(0, 1, 32'h00010000, 0, 32'h0000FFFF, 1, "R4 uw one past");
        clear_flag();
    endtask

    task automatic t_sticky();
        clip(1, 0, 32'h00001000, 0, 32'h0000007F, 1, "R7 set");
        clip(1, 0, 32'h00000005, 0, 32'h00000005, 1, "R7 no clear by pass");
        clip(0, 1, 32'h00001234, 0, 32'h00001234, 1, "R7 still set");
        clear_flag();
        clip(0, 0, 32'h00000300, 1, 32'h000000FF, 1, "R8 clamp beats clear");
        clip(0, 0, 32'h00000010, 1, 32'h00000010, 0, "R8 clear with pass");
    endtask

    task automatic t_hold();
        clip(1, 1, 32'h00000abc, 0, 32'h00000abc, 0, "R6 load");
        @(negedge clk);
        operand = 32'hDEADBEEF; op_signed = 1'b0; op_word = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R6 hold result", result, 32'h00000abc);
        check("R6 hold flag", {31'b0, clip_flag}, 32'd0);
    endtask

    task automatic dec_check(logic [15:0] w, bit hit, bit sgn, bit wrd, logic [3:0] r, string tag);
        insn = w;
        #1;
        check({tag, " hit"}, {31'b0, d_hit}, {31'b0, hit});
        if (hit) begin
            check({tag, " signed"}, {31'b0, d_sgn}, {31'b0, sgn});
            check({tag, " word"}, {31'b0, d_wrd}, {31'b0, wrd});
            check({tag, " reg"}, {28'b0, d_reg}, {28'b0, r});
        end
    endtask

    task automatic t_decode();
        dec_check(16'h4391, 1, 1, 0, 4'd3, "R9 signed byte");
        dec_check(16'h4A95, 1, 1, 1, 4'd10, "R9 signed word");
        dec_check(16'h4F81, 1, 0, 0, 4'd15, "R9 unsigned byte");
        dec_check(16'h4085, 1, 0, 1, 4'd0, "R9 unsigned word");
        dec_check(16'h4594, 0, 0, 0, 4'd0, "R9 miss divide");
        dec_check(16'h4210, 0, 0, 0, 4'd0, "R9 miss decrement");
        dec_check(16'h5391, 0, 0, 0, 4'd0, "R9 miss prefix");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bounds();
        t_signed();
        t_unsigned();
        t_sticky();
        t_hold();
        t_decode();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule